// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block lives in the memory-access stage of a 32-bit little-endian load/store pipeline. On the store side it spreads a narrow datum across the whole write bus and computes one write enable per byte lane. The memory then keeps only the lanes that are enabled. On the load side it takes the raw word returned by memory and rotates it right so that the addressed byte or halfword ends up in the low bits. It then fills the upper bits with zeros or with copies of the datum's top bit.

Each access is described by a valid strobe, a store/load flag, a size code, a signed flag, the low address bits, the register value to store and the word read from memory. Every result is registered once at the stage boundary, so the outputs for an access appear one clock after it is presented. A halfword on an odd address, or a word that is not on a 4-byte boundary, raises a misalignment flag for that access and suppresses its write enables.

Top module: `ls_align_unit`

## Requirements
- R1: While rstN is low, wrData, byteEn, loadData and misalign are all zero.
- R2: A valid store with accSize 00 (byte) gives wrData equal to storeData[7:0] copied into all four lanes. byteEn has exactly one bit set, at index accAddrLow, where bit 0 is lane 0 = wrData[7:0].
- R3: A valid store with accSize 01 (halfword) gives wrData equal to storeData[15:0] in both halves. byteEn is 0011 at address 0 and 1100 at address 2.
- R4: A valid aligned store with accSize 10 (word) gives wrData equal to storeData and byteEn equal to 1111.
- R5: A valid access raises misalign in the next cycle if it is a halfword with accAddrLow[0]=1, or a word with accAddrLow not 00. For such an access byteEn is 0000. This applies to stores and loads alike.
- R6: A valid byte load rotates readWord right by 8*accAddrLow and returns the low byte. With accSigned=1 it is sign-extended, otherwise zero-extended.
- R7: A valid halfword load rotates readWord right by 8*accAddrLow and returns the low 16 bits, sign- or zero-extended by accSigned. A misaligned halfword still returns these rotated bits.
- R8: A valid word load returns readWord rotated right by 8*accAddrLow. This is readWord unchanged when aligned, and the rotated word when misaligned.
- R9: Results appear exactly one clock after the access. In a cycle after accValid is low, byteEn and misalign are zero and wrData and loadData keep their last values, so misalign lasts one cycle per misaligned access.
- R10: A valid load (accWrite=0) never asserts any byte enable.
- R11: The size code 11 behaves exactly as a word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | An access is presented this cycle |
| accWrite | input | 1 | 1 = store, 0 = load |
| accSize | input | 2 | 00 byte, 01 halfword, 10 or 11 word |
| accSigned | input | 1 | 1 = sign-extend narrow loads |
| accAddrLow | input | 2 | Address bits 1:0 of the access |
| storeData | input | 32 | Register value to be stored |
| readWord | input | 32 | Raw word read from memory |
| wrData | output | 32 | Lane-replicated write data |
| byteEn | output | 4 | Per-lane write enables |
| loadData | output | 32 | Rotated and extended load result |
| misalign | output | 1 | Access was misaligned |

## Verification
The hardest cases are the misaligned ones. For a misaligned access the flag must rise while the write enables stay off, yet the load path must still return the rotated data, and the flag must drop again as soon as the access stream goes idle. The stimulus covers this by issuing misaligned halfword and word accesses of both directions back to back, followed by an idle cycle. Narrow loads use read words whose addressed datum has its top bit set and whose other lanes hold different patterns. This exposes any mistake in the rotation or in the choice of fill bit.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } accSize_e;

  typedef struct packed {
    logic capture;
    logic selByte;
    logic selHalf;
    logic signFill;
  } alignStrobes_t;
endpackage

// File: rtl/lsa_ctrl.sv
module lsa_ctrl
  import lsa_pkg::*;
#(
  parameter int LANES = 4,
  localparam int LSB_W = $clog2(LANES)
) (
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [1:0]       accSize,
  input  logic             accSigned,
  input  logic [LSB_W-1:0] accAddrLow,
  output alignStrobes_t    strobes,
  output logic [LANES-1:0] byteEnNext,
  output logic             misalignNext
);
  accSize_e sizeCode;
  logic isByte, isHalf, isWord;

  assign sizeCode = accSize_e'(accSize);
  assign isByte   = (sizeCode == SZ_BYTE);
  assign isHalf   = (sizeCode == SZ_HALF);
  assign isWord   = !isByte && !isHalf;

  assign misalignNext = accValid &&
    ((isHalf && accAddrLow[0]) || (isWord && (accAddrLow != '0)));

  always_comb begin
    byteEnNext = '0;
    if (accValid && accWrite && !misalignNext) begin
      if (isByte)      byteEnNext = LANES'(1) << accAddrLow;
      else if (isHalf) byteEnNext = LANES'(3) << accAddrLow;
      else             byteEnNext = '1;
    end
  end

  always_comb begin
    strobes.capture  = accValid;
    strobes.selByte  = isByte;
    strobes.selHalf  = isHalf;
    strobes.signFill = accSigned;
  end
endmodule

// File: rtl/lsa_datapath.sv
module lsa_datapath
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LSB_W = $clog2(LANES),
  localparam int HALVES = DATA_W / 16
) (
  input  alignStrobes_t     strobes,
  input  logic [LSB_W-1:0]  accAddrLow,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] readWord,
  output logic [DATA_W-1:0] wrDataNext,
  output logic [DATA_W-1:0] loadDataNext
);
  logic [DATA_W-1:0]   byteRep, halfRep, rotated;
  logic [2*DATA_W-1:0] doubled;

  for (genvar g = 0; g < LANES; g++) begin : g_byteRep
    assign byteRep[g*8 +: 8] = storeData[7:0];
  end
  for (genvar g = 0; g < HALVES; g++) begin : g_halfRep
    assign halfRep[g*16 +: 16] = storeData[15:0];
  end

  always_comb begin
    if (strobes.selByte)      wrDataNext = byteRep;
    else if (strobes.selHalf) wrDataNext = halfRep;
    else                      wrDataNext = storeData;
  end

  assign doubled = {readWord, readWord} >> ({accAddrLow, 3'b000});
  assign rotated = doubled[DATA_W-1:0];

  always_comb begin
    if (strobes.selByte)
      loadDataNext = {{(DATA_W-8){strobes.signFill & rotated[7]}}, rotated[7:0]};
    else if (strobes.selHalf)
      loadDataNext = {{(DATA_W-16){strobes.signFill & rotated[15]}}, rotated[15:0]};
    else
      loadDataNext = rotated;
  end
endmodule

// File: rtl/ls_align_unit.sv
module ls_align_unit
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LSB_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [1:0]        accSize,
  input  logic              accSigned,
  input  logic [LSB_W-1:0]  accAddrLow,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] readWord,
  output logic [DATA_W-1:0] wrData,
  output logic [LANES-1:0]  byteEn,
  output logic [DATA_W-1:0] loadData,
  output logic              misalign
);
  alignStrobes_t     strobes;
  logic [LANES-1:0]  byteEnNext;
  logic              misalignNext;
  logic [DATA_W-1:0] wrDataNext, loadDataNext;

  lsa_ctrl #(.LANES(LANES)) i_ctrl (
    .accValid(accValid), .accWrite(accWrite), .accSize(accSize),
    .accSigned(accSigned), .accAddrLow(accAddrLow), .strobes(strobes),
    .byteEnNext(byteEnNext), .misalignNext(misalignNext)
  );

  lsa_datapath #(.DATA_W(DATA_W)) i_dp (
    .strobes(strobes), .accAddrLow(accAddrLow), .storeData(storeData),
    .readWord(readWord), .wrDataNext(wrDataNext), .loadDataNext(loadDataNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrData   <= '0;
      loadData <= '0;
      byteEn   <= '0;
      misalign <= 1'b0;
    end else begin
      byteEn   <= byteEnNext;
      misalign <= misalignNext;
      if (strobes.capture) begin
        wrData   <= wrDataNext;
        loadData <= loadDataNext;
      end
    end
  end
endmodule

// File: rtl/lsa_checker.sv
module lsa_checker #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LSB_W = $clog2(LANES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              accWrite,
  input logic [1:0]        accSize,
  input logic              accSigned,
  input logic [LSB_W-1:0]  accAddrLow,
  input logic [DATA_W-1:0] wrData,
  input logic [LANES-1:0]  byteEn,
  input logic [DATA_W-1:0] loadData,
  input logic              misalign
);
  assert_misalign_no_enables_R5: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> (byteEn == '0));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> (byteEn == '0 && !misalign));

  assert_load_no_enables_R10: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite) |=> (byteEn == '0));

  assert_byte_store_single_lane_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite && accSize == 2'b00) |=> ($countones(byteEn) == 1));

  assert_half_store_copies_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite && accSize == 2'b01) |=> (wrData[31:16] == wrData[15:0]));

  assert_unsigned_byte_fill_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite && accSize == 2'b00 && !accSigned) |=> (loadData[DATA_W-1:8] == '0));
endmodule

bind ls_align_unit lsa_checker #(.DATA_W(DATA_W)) i_lsa_checker (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
  .accSize(accSize), .accSigned(accSigned), .accAddrLow(accAddrLow),
  .wrData(wrData), .byteEn(byteEn), .loadData(loadData), .misalign(misalign)
);

// File: tb/test_ls_align_unit.sv
`timescale 1ns/1ps
module test_ls_align_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0, accWrite = 1'b0, accSigned = 1'b0;
  logic [1:0]  accSize = 2'b00, accAddrLow = 2'b00;
  logic [31:0] storeData = '0, readWord = '0;
  logic [31:0] wrData, loadData;
  logic [3:0]  byteEn;
  logic        misalign;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] wr;
    logic [31:0] ld;
    logic [3:0]  be;
    logic        mis;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];
  logic [31:0] lastWr = '0, lastLd = '0;

  always #10 clk = ~clk;

  ls_align_unit i_ls_align_unit (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accSize(accSize), .accSigned(accSigned), .accAddrLow(accAddrLow),
    .storeData(storeData), .readWord(readWord), .wrData(wrData),
    .byteEn(byteEn), .loadData(loadData), .misalign(misalign)
  );

  function automatic logic [31:0] rotRight(logic [31:0] w, logic [1:0] a);
    case (a)
      2'd0: return w;
      2'd1: return {w[7:0], w[31:8]};
      2'd2: return {w[15:0], w[31:16]};
      default: return {w[23:0], w[31:24]};
    endcase
  endfunction

  task automatic apply(input logic v, input logic w, input logic [1:0] sz,
                       input logic sg, input logic [1:0] a,
                       input logic [31:0] sd, input logic [31:0] rw, input string tag);
    expItem_t e;
    logic isB, isH, isW;
    logic [31:0] r;
    @(negedge clk);
    accValid = v; accWrite = w; accSize = sz; accSigned = sg;
    accAddrLow = a; storeData = sd; readWord = rw;
    isB = (sz == 2'b00); isH = (sz == 2'b01); isW = !isB && !isH;
    e.mis = v && ((isH && a[0]) || (isW && a != 2'b00));
    if (v && w && !e.mis)
      e.be = isB ? (4'b0001 << a) : isH ? ((a == 2'd0) ? 4'b0011 : 4'b1100) : 4'b1111;
    else
      e.be = 4'b0000;
    if (v) begin
      lastWr = isB ? {4{sd[7:0]}} : isH ? {2{sd[15:0]}} : sd;
      r = rotRight(rw, a);
      if (isB)      lastLd = sg ? {{24{r[7]}}, r[7:0]} : {24'b0, r[7:0]};
      else if (isH) lastLd = sg ? {{16{r[15]}}, r[15:0]} : {16'b0, r[15:0]};
      else          lastLd = r;
    end
    e.wr = lastWr; e.ld = lastLd; e.tag = tag;
    expQ.push_back(e);
  endtask

  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (wrData !== e.wr || loadData !== e.ld || byteEn !== e.be || misalign !== e.mis) begin
        fails++;
        $display("FAIL %s: got wr=%h ld=%h be=%b mis=%b exp wr=%h ld=%h be=%b mis=%b",
                 e.tag, wrData, loadData, byteEn, misalign, e.wr, e.ld, e.be, e.mis);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #35;
    checks++;
    if (wrData !== '0 || loadData !== '0 || byteEn !== '0 || misalign !== 1'b0) begin
      fails++;
      $display("FAIL R1: got wr=%h ld=%h be=%b mis=%b exp all zero", wrData, loadData, byteEn, misalign);
    end
    @(negedge clk); rstN = 1'b1;

    for (int a = 0; a < 4; a++)   // R2 byte stores on every lane
      apply(1, 1, 2'b00, 0, 2'(a), 32'h1234_56A0 + 32'(a), 32'h0, "R2");
    apply(1, 1, 2'b01, 0, 2'd0, 32'hDEAD_BEEF, 32'h0, "R3");
    apply(1, 1, 2'b01, 0, 2'd2, 32'h0000_8001, 32'h0, "R3");
    apply(1, 1, 2'b10, 0, 2'd0, 32'hCAFE_F00D, 32'h0, "R4");
    apply(1, 1, 2'b11, 0, 2'd0, 32'h0BAD_C0DE, 32'h0, "R11");
    apply(1, 1, 2'b11, 0, 2'd2, 32'h0BAD_C0DE, 32'h0, "R11");
    // R5 misaligned stores and loads back to back, then idle (R9)
    apply(1, 1, 2'b01, 0, 2'd1, 32'h1111_2222, 32'h0, "R5");
    apply(1, 1, 2'b01, 0, 2'd3, 32'h3333_4444, 32'h0, "R5");
    apply(1, 1, 2'b10, 0, 2'd1, 32'h5555_6666, 32'h0, "R5");
    apply(1, 0, 2'b10, 0, 2'd2, 32'h0, 32'h8899_AABB, "R5");
    apply(0, 1, 2'b01, 0, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9");
    apply(0, 0, 2'b00, 1, 2'd0, 32'h0, 32'h7777_7777, "R9");
    for (int a = 0; a < 4; a++) begin // R6 byte loads, signed and unsigned
      apply(1, 0, 2'b00, 1, 2'(a), 32'h0, 32'h80F1_7F92, "R6");
      apply(1, 0, 2'b00, 0, 2'(a), 32'h0, 32'h80F1_7F92, "R6");
    end
    apply(1, 0, 2'b01, 1, 2'd0, 32'h0, 32'h1234_9876, "R7");
    apply(1, 0, 2'b01, 0, 2'd0, 32'h1234_9876, 32'h1234_9876, "R7");
    apply(1, 0, 2'b01, 1, 2'd2, 32'h0, 32'hF00D_1234, "R7");
    apply(1, 0, 2'b01, 1, 2'd1, 32'h0, 32'hA5C3_8E01, "R7");
    apply(1, 0, 2'b10, 0, 2'd0, 32'h0, 32'hA1B2_C3D4, "R8");
    apply(1, 0, 2'b10, 1, 2'd3, 32'h0, 32'hA1B2_C3D4, "R8");
    apply(1, 0, 2'b11, 0, 2'd0, 32'h0, 32'h0102_0304, "R10");
    apply(0, 0, 2'b00, 0, 2'd0, 32'h0, 32'h0, "R9");
    @(negedge clk); accValid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule